// File: doc/BRIEF.md
# Serial-Host GPIO Port Controller

This block turns a seven-pin parallel data port into general-purpose I/O for the times when the host talks to the device over a serial link and the parallel port is otherwise idle. Two byte-wide registers sit on a simple address/data bus. The direction register holds one output-driver enable per pin and a flag that turns on the UART auxiliary handshake lines. The level register holds one output level per pin and a master bit that switches the port into I/O mode.

Each pin is driven only when I/O mode is on, the pin's direction bit is set, a serial host interface is selected, and the pin has not been taken for another use. In SPI mode, and in UART mode with the handshake lines on, only the five low pins are free. An optional clock output takes pin 1. While I/O mode is on, reading the level register returns the synchronized pin levels rather than the stored bits.

Top module: `gpio_port_ctl`

## Requirements
- R1: A synchronous active-high reset sets the direction register to 0x80 and the level register to 0x00, clears the input synchronizer and leaves every pin undriven.
- R2: A write happens on the rising edge where wr_en is high and addr is 0x33 (direction) or 0x34 (level). Reading 0x33 returns the stored direction byte. Reading 0x34 while level bit 7 is 0 returns the stored level byte.
- R3: Writes to any other address change neither register. Reads of any other address return 0x00.
- R4: pin_oe[n] is the AND of level bit 7, direction bit n, a serial host mode and pin n being free. host_mode encoding: 00 parallel, 01 SPI, 10 UART, 11 I2C. Parallel mode drives no pin.
- R5: In SPI mode, and in UART mode with direction bit 7 set, pins 5 and 6 are never driven.
- R6: While clkout_d1 is high, pin 1 is never driven.
- R7: While level bit 7 is 1, reading 0x34 returns bit 7 = 1 and, in bits 6:0, pin_in as it was two rising edges earlier.
- R8: pin_out[n] equals level bit n when pin_oe[n] is 1, and is 0 otherwise.
- R9: aux_line_en is 1 exactly when direction bit 7 is 1 and host_mode is UART.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 2 | Active host interface (00 parallel, 01 SPI, 10 UART, 11 I2C) |
| clkout_d1 | input | 1 | Clock output option that takes pin 1 |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pin_in | input | 7 | Pin levels seen at the pads |
| pin_oe | output | 7 | Per-pin output-driver enable |
| pin_out | output | 7 | Per-pin driven level |
| aux_line_en | output | 1 | Enable for the UART handshake lines |

## Verification
The bench targets how the masks combine. It uses UART mode with the handshake flag both on and off, the clock option together with SPI limiting, and parallel mode with every enable set. If the SPI/UART limit and the pin-1 mask were ORed in the wrong order, or if the serial-mode check were missing, a pin that has been taken for another use would be driven. It also reads the level register just after I/O mode is switched on and while pin_in is changing. A readback with too few or too many synchronizer stages shows the wrong cycle's levels, and a readback mux that ignores the mode bit returns stored bits in place of pin levels. Writes to neighbouring unmapped addresses and reads just after reset catch a decoder that aliases addresses and reset values that are wrong.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      HOST_PARALLEL = 2'b00,
      HOST_SPI      = 2'b01,
      HOST_UART     = 2'b10,
      HOST_I2C      = 2'b11
   } host_mode_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h33,
   parameter logic [ADDR_W-1:0] LVL_ADDR = 8'h34,
   parameter logic [DATA_W-1:0] DIR_RST  = 8'h80,
   parameter logic [DATA_W-1:0] LVL_RST  = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] lvl_q
);
   if (DIR_ADDR == LVL_ADDR) begin : g_bad_map
      $error("gpio_regs: register addresses collide");
   end

   logic hit_dir;
   logic hit_lvl;

   always_comb begin
      hit_dir = wr_en && (addr == DIR_ADDR);
      hit_lvl = wr_en && (addr == LVL_ADDR);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= DIR_RST;
         lvl_q <= LVL_RST;
      end else begin
         if (hit_dir) dir_q <= wdata;
         if (hit_lvl) lvl_q <= wdata;
      end
   end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_sync: at least two stages are required");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= '0;
            else     stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_avail.sv
module gpio_avail
   import gpio_pkg::*;
#(
   parameter int NPINS      = 7,
   parameter int LIMIT_PINS = 5,
   parameter int CLKOUT_PIN = 1
) (
   input  host_mode_e       mode,
   input  logic             line_en,
   input  logic             clkout_sel,
   output logic [NPINS-1:0] avail
);
   if (LIMIT_PINS > NPINS || CLKOUT_PIN >= NPINS) begin : g_bad_cfg
      $error("gpio_avail: pin limits exceed port width");
   end

   logic serial_mode;
   logic limited;

   always_comb begin
      serial_mode = (mode != HOST_PARALLEL);
      limited     = (mode == HOST_SPI) || ((mode == HOST_UART) && line_en);
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic limit_ok;
      logic clk_ok;
      if (p < LIMIT_PINS) begin : g_low
         assign limit_ok = 1'b1;
      end else begin : g_high
         assign limit_ok = !limited;
      end
      if (p == CLKOUT_PIN) begin : g_clk
         assign clk_ok = !clkout_sel;
      end else begin : g_noclk
         assign clk_ok = 1'b1;
      end
      assign avail[p] = serial_mode && limit_ok && clk_ok;
   end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
   import gpio_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NPINS      = 7,
   parameter int LIMIT_PINS = 5,
   parameter int CLKOUT_PIN = 1,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h33,
   parameter logic [ADDR_W-1:0] LVL_ADDR = 8'h34,
   localparam int DATA_W = NPINS + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        host_mode,
   input  logic              clkout_d1,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pin_out,
   output logic              aux_line_en
);
   localparam int FLAG_BIT = DATA_W - 1;
   localparam logic [DATA_W-1:0] DIR_RST = DATA_W'(1) << FLAG_BIT;
   localparam logic [DATA_W-1:0] LVL_RST = '0;

   host_mode_e       mode;
   logic [DATA_W-1:0] dir_q;
   logic [DATA_W-1:0] lvl_q;
   logic [NPINS-1:0]  avail;
   logic [NPINS-1:0]  pins_sync;
   logic              io_mode;
   logic              line_en;

   assign mode    = host_mode_e'(host_mode);
   assign io_mode = lvl_q[FLAG_BIT];
   assign line_en = dir_q[FLAG_BIT];

   gpio_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DIR_ADDR(DIR_ADDR), .LVL_ADDR(LVL_ADDR),
      .DIR_RST(DIR_RST), .LVL_RST(LVL_RST)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .dir_q(dir_q), .lvl_q(lvl_q)
   );

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
   );

   gpio_avail #(
      .NPINS(NPINS), .LIMIT_PINS(LIMIT_PINS), .CLKOUT_PIN(CLKOUT_PIN)
   ) u_avail (
      .mode(mode), .line_en(line_en), .clkout_sel(clkout_d1), .avail(avail)
   );

   always_comb begin
      pin_oe      = io_mode ? (dir_q[NPINS-1:0] & avail) : '0;
      pin_out     = lvl_q[NPINS-1:0] & pin_oe;
      aux_line_en = line_en && (mode == HOST_UART);
   end

   always_comb begin
      if (addr == DIR_ADDR)
         rdata = dir_q;
      else if (addr == LVL_ADDR)
         rdata = io_mode ? {1'b1, pins_sync} : lvl_q;
      else
         rdata = '0;
   end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
   parameter int ADDR_W     = 8,
   parameter int NPINS      = 7,
   parameter int LIMIT_PINS = 5,
   parameter int CLKOUT_PIN = 1,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h33,
   parameter logic [ADDR_W-1:0] LVL_ADDR = 8'h34
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        host_mode,
   input logic              clkout_d1,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [NPINS:0]    wdata,
   input logic [NPINS:0]    dir_q,
   input logic [NPINS:0]    lvl_q,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPINS-1:0]  pin_out,
   input logic              aux_line_en
);
   assert_reset_release_R1: assert property (@(posedge clk)
      rst |=> (pin_oe == '0));

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == DIR_ADDR) |=> (dir_q == $past(wdata)));

   assert_lvl_write_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == LVL_ADDR) |=> (lvl_q == $past(wdata)));

   assert_other_addr_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr != DIR_ADDR && addr != LVL_ADDR) |=> ($stable(dir_q) && $stable(lvl_q)));

   assert_parallel_off_R4: assert property (@(posedge clk) disable iff (rst)
      (host_mode == 2'b00) |-> (pin_oe == '0));

   assert_limit_R5: assert property (@(posedge clk) disable iff (rst)
      (host_mode == 2'b01 || (host_mode == 2'b10 && dir_q[NPINS]))
         |-> ((pin_oe >> LIMIT_PINS) == '0));

   assert_clkout_R6: assert property (@(posedge clk) disable iff (rst)
      clkout_d1 |-> !pin_oe[CLKOUT_PIN]);

   assert_undriven_low_R8: assert property (@(posedge clk) disable iff (rst)
      ((pin_out & ~pin_oe) == '0));

   assert_aux_uart_R9: assert property (@(posedge clk) disable iff (rst)
      aux_line_en |-> (host_mode == 2'b10));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(
   .ADDR_W(ADDR_W), .NPINS(NPINS), .LIMIT_PINS(LIMIT_PINS),
   .CLKOUT_PIN(CLKOUT_PIN), .DIR_ADDR(DIR_ADDR), .LVL_ADDR(LVL_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .host_mode(host_mode), .clkout_d1(clkout_d1),
   .wr_en(wr_en), .addr(addr), .wdata(wdata), .dir_q(dir_q), .lvl_q(lvl_q),
   .pin_oe(pin_oe), .pin_out(pin_out), .aux_line_en(aux_line_en)
);

// File: tb/tb_gpio_port_ctl.sv
module tb_gpio_port_ctl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] host_mode = 2'b00;
   logic       clkout_d1 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [6:0] pin_in = 7'h00;
   logic [6:0] pin_oe;
   logic [6:0] pin_out;
   logic       aux_line_en;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] m_dir = 8'h80;
   logic [7:0] m_lvl = 8'h00;
   logic [6:0] m_s0 = 7'h00;
   logic [6:0] m_s1 = 7'h00;
   bit         m_fresh = 1'b0;

   always #5 clk = ~clk;

   gpio_port_ctl dut (
      .clk(clk), .rst(rst), .host_mode(host_mode), .clkout_d1(clkout_d1),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
      .aux_line_en(aux_line_en)
   );

   function automatic logic [6:0] exp_avail(logic [1:0] md, logic le, logic ck);
      logic [6:0] a;
      a = 7'h7F;
      if (md == 2'b01 || (md == 2'b10 && le)) a = 7'h1F;
      if (ck) a[1] = 1'b0;
      if (md == 2'b00) a = 7'h00;
      return a;
   endfunction

   function automatic logic [6:0] exp_oe();
      return m_lvl[7] ? (m_dir[6:0] & exp_avail(host_mode, m_dir[7], clkout_d1)) : 7'h00;
   endfunction

   function automatic logic [7:0] exp_rd();
      if (addr == 8'h33) return m_dir;
      if (addr == 8'h34) return m_lvl[7] ? {1'b1, m_s1} : m_lvl;
      return 8'h00;
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(logic r, logic [1:0] md, logic ck, logic w,
                       logic [7:0] a, logic [7:0] d, logic [6:0] p);
      string tg;
      logic [6:0] eoe;
      @(negedge clk);
      rst = r; host_mode = md; clkout_d1 = ck; wr_en = w;
      addr = a; wdata = d; pin_in = p;
      #1;
      if (!m_fresh) begin
         eoe = exp_oe();
         if (md == 2'b01 || (md == 2'b10 && m_dir[7])) tg = "R5";
         else if (ck) tg = "R6";
         else tg = "R4";
         check(tg, "pin_oe", {1'b0, pin_oe}, {1'b0, eoe});
         check("R8", "pin_out", {1'b0, pin_out}, {1'b0, m_lvl[6:0] & eoe});
         check("R9", "aux_line_en", {7'b0, aux_line_en}, {7'b0, (m_dir[7] && md == 2'b10)});
      end else begin
         check("R1", "pin_oe after reset", {1'b0, pin_oe}, 8'h00);
      end
      if (m_fresh) tg = "R1";
      else if (a == 8'h34 && m_lvl[7]) tg = "R7";
      else if (a == 8'h33 || a == 8'h34) tg = "R2";
      else tg = "R3";
      check(tg, "rdata", rdata, exp_rd());
      @(posedge clk);
      if (r) begin
         m_dir = 8'h80; m_lvl = 8'h00; m_s0 = 7'h00; m_s1 = 7'h00; m_fresh = 1'b1;
      end else begin
         if (w && a == 8'h33) m_dir = d;
         if (w && a == 8'h34) m_lvl = d;
         m_s1 = m_s0; m_s0 = p; m_fresh = 1'b0;
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      // R1: reset values
      step(1, 2'b11, 0, 0, 8'h33, 8'h00, 7'h00);
      step(0, 2'b11, 0, 0, 8'h33, 8'h00, 7'h00);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h00);
      // R4: I2C mode, all pins driven
      step(0, 2'b11, 0, 1, 8'h33, 8'h7F, 7'h00);
      step(0, 2'b11, 0, 1, 8'h34, 8'h80 | 8'h55, 7'h2A);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h2A);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h2A);
      // R4: parallel mode off
      step(0, 2'b00, 0, 0, 8'h34, 8'h00, 7'h7F);
      // R5: SPI limit, UART without and with handshake flag
      step(0, 2'b01, 0, 0, 8'h33, 8'h00, 7'h7F);
      step(0, 2'b10, 0, 0, 8'h33, 8'h00, 7'h7F);
      step(0, 2'b10, 0, 1, 8'h33, 8'hFF, 7'h00);
      step(0, 2'b10, 0, 0, 8'h33, 8'h00, 7'h00);
      // R6: clock option with SPI limit
      step(0, 2'b01, 1, 0, 8'h34, 8'h00, 7'h11);
      step(0, 2'b11, 1, 0, 8'h34, 8'h00, 7'h22);
      // R3: neighbouring unmapped addresses
      step(0, 2'b11, 0, 1, 8'h35, 8'h00, 7'h00);
      step(0, 2'b11, 0, 1, 8'h32, 8'h00, 7'h00);
      step(0, 2'b11, 0, 0, 8'h35, 8'h00, 7'h00);
      step(0, 2'b11, 0, 0, 8'h33, 8'h00, 7'h00);
      // R2: I/O mode off shows stored level byte
      step(0, 2'b11, 0, 1, 8'h34, 8'h3C, 7'h7F);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h7F);
      // R7: switch I/O mode on while pins change
      step(0, 2'b11, 0, 1, 8'h34, 8'hC3, 7'h01);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h02);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h04);
      step(0, 2'b11, 0, 0, 8'h34, 8'h00, 7'h08);
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a;
         int sel;
         sel = $urandom_range(0, 9);
         a = (sel < 4) ? 8'h33 : (sel < 8) ? 8'h34 : 8'($urandom);
         step(($urandom_range(0, 99) == 0), 2'($urandom), ($urandom_range(0, 3) == 0),
              ($urandom_range(0, 2) == 0), a, 8'($urandom), 7'($urandom));
      end
      finish_run();
   end
endmodule